// File: doc/BRIEF.md
# Epoch-Boundary Issue Stall Controller

This block sits in front of an instruction issue port and decides, cycle by cycle, whether the next instruction may leave. It watches a free-running global 8-bit time counter that is shared across chips. It also keeps a local 8-bit cycle counter of its own. An epoch boundary is the cycle on which the global counter rolls from its top value back to zero. Several operations hold issue until such a boundary:

- an align operation;
- a start sequence for the sending side, which aligns and then fires a start strobe on the boundary;
- a start sequence for the receiving side, which waits for the partner's vector, holds it in a buffer and releases a receive on the next boundary.

A fourth operation, the time-correction stall, stops issue for a given number of cycles. It then realigns the local counter to global time. The difference between global and local time is reported continuously as the drift value. Instructions arrive already decoded as a small opcode plus an 8-bit argument.

Top module: `epoch_issue_gate`

## Requirements
- R1: While reset is held and on the first cycle after its release, `issueEn` is 1, `sendStrobe`, `recvFire` and `protoErr` are 0, `recvData` is 0, and the local counter starts at 0.
- R2: An epoch boundary is a cycle where `globalCnt` is 0 and it was 255 on the previous cycle. An accepted align operation (`instOp`=1) drives `issueEn` to 0 from the next cycle up to the first later boundary. On that boundary `issueEn` is 1. An align accepted on a boundary cycle waits for the following boundary.
- R3: An instruction is accepted when `instValid` and `issueEn` are both 1. Plain operations (`instOp` 0, 5, 6, 7) leave `issueEn` at 1.
- R4: A sender start (`instOp`=2) stalls issue like R2. On the boundary that ends the stall, `sendStrobe` is 1 for exactly that cycle, together with `issueEn`=1.
- R5: A receiver start (`instOp`=3) holds `issueEn` at 0 while waiting. The first `vecValid` cycle in that wait stores `vecData`, which appears on `recvData` from the next cycle.
- R6: After a vector is stored, `recvFire` and `issueEn` are 1 on the first boundary cycle strictly after the storing cycle, and issue resumes. A vector stored on a boundary cycle is released 256 cycles later.
- R7: A correction stall (`instOp`=4) with argument N>0 holds `issueEn` at 0 for exactly N cycles after the accepting cycle. With N=0 there is no stall.
- R8: `drift` equals `globalCnt` minus the local counter, modulo 256. The local counter advances by one each cycle. When a correction stall ends, the local counter is loaded with `globalCnt`+1 on its last stalled cycle (for N=0, on the accepting cycle), so `drift` reads 0 while the global counter advances normally.
- R9: A `vecValid` cycle while the block is neither waiting for a vector nor holding one makes `protoErr` 1 for exactly the following cycle.
- R10: A second vector that arrives while one is already held is ignored: `recvData` keeps the first value and `protoErr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | A decoded instruction is offered |
| instOp | input | 3 | Operation code (0 plain, 1 align, 2 sender start, 3 receiver start, 4 correction stall) |
| instArg | input | 8 | Stall length for the correction stall |
| globalCnt | input | 8 | Global aligned time counter |
| vecValid | input | 1 | Start vector from the partner is present |
| vecData | input | 32 | Start vector payload |
| issueEn | output | 1 | Issue is allowed this cycle |
| sendStrobe | output | 1 | Send the start vector to the partner now |
| recvFire | output | 1 | Release the receive of the buffered vector |
| recvData | output | 32 | Buffered start vector |
| drift | output | 8 | Global minus local time, modulo 256 |
| protoErr | output | 1 | A vector arrived when none was expected |

## Verification
The properties assume that `globalCnt` only reaches 0 after 255 on a boundary. They also assume that an instruction counts only when offered with `issueEn` high, and that the stall argument is stable in its accepting cycle. The stimulus counts the global value up by one per cycle and wraps it naturally. It breaks that counting only by forward jumps placed far from the 255 to 0 step, so no false boundary ever appears. Drift is created only through those jumps.

// File: rtl/epoch_gate_pkg.sv
package epoch_gate_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_PLAIN        = 3'd0,
    OP_ALIGN        = 3'd1,
    OP_SEND_START   = 3'd2,
    OP_RECV_START   = 3'd3,
    OP_TIME_CORRECT = 3'd4
  } gateOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESKEW_WAIT,
    ST_POLL,
    ST_ARMED,
    ST_RUN_STALL,
    ST_RUN
  } gateState_e;

  typedef struct packed {
    logic loadStall;   // start the correction stall counter
    logic localLoad;   // realign local time to global time
    logic captureVec;  // store the incoming start vector
    logic strayVec;    // vector seen outside the receive window
  } gateStrobes_t;

endpackage

// File: rtl/epoch_gate_dp.sv
module epoch_gate_dp
  import epoch_gate_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int STALL_W = 8,
  parameter int VEC_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   globalCnt,
  input  logic [STALL_W-1:0] instArg,
  input  logic [VEC_W-1:0]   vecData,
  input  gateStrobes_t       strobes,
  output logic               wrapEdge,
  output logic               stallLast,
  output logic               argIsZero,
  output logic [CNT_W-1:0]   drift,
  output logic [VEC_W-1:0]   recvData,
  output logic               protoErr
);

  localparam logic [CNT_W-1:0]   CNT_TOP  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]   CNT_ONE  = CNT_W'(1);
  localparam logic [STALL_W-1:0] STALL_ONE = STALL_W'(1);

  logic [CNT_W-1:0]   prevGlobal;
  logic [CNT_W-1:0]   localCnt;
  logic [STALL_W-1:0] stallCnt;
  logic [VEC_W-1:0]   vecBuf;
  logic               errQ;

  always_comb begin
    wrapEdge  = (prevGlobal == CNT_TOP) && (globalCnt == '0);
    stallLast = (stallCnt == STALL_ONE);
    argIsZero = (instArg == '0);
    drift     = globalCnt - localCnt;
    recvData  = vecBuf;
    protoErr  = errQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevGlobal <= '0;
      localCnt   <= '0;
      stallCnt   <= '0;
      vecBuf     <= '0;
      errQ       <= 1'b0;
    end else begin
      prevGlobal <= globalCnt;
      if (strobes.localLoad) localCnt <= globalCnt + CNT_ONE;
      else                   localCnt <= localCnt + CNT_ONE;
      if (strobes.loadStall)    stallCnt <= instArg;
      else if (stallCnt != '0)  stallCnt <= stallCnt - STALL_ONE;
      if (strobes.captureVec) vecBuf <= vecData;
      errQ <= strobes.strayVec;
    end
  end

endmodule

// File: rtl/epoch_gate_ctrl.sv
module epoch_gate_ctrl
  import epoch_gate_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            instValid,
  input  logic [OP_W-1:0] instOp,
  input  logic            argIsZero,
  input  logic            wrapEdge,
  input  logic            stallLast,
  input  logic            vecValid,
  output logic            issueEn,
  output logic            sendStrobe,
  output logic            recvFire,
  output gateStrobes_t    strobes
);

  gateState_e state, stateNext;
  logic       sendPend;
  logic       accept;
  logic       inRecvWindow;

  always_comb begin
    inRecvWindow = (state == ST_POLL) || (state == ST_ARMED);
    issueEn      = (state == ST_IDLE) || (state == ST_RUN) ||
                   (wrapEdge && ((state == ST_DESKEW_WAIT) || (state == ST_ARMED)));
    accept       = instValid && issueEn;
    sendStrobe   = (state == ST_DESKEW_WAIT) && wrapEdge && sendPend;
    recvFire     = (state == ST_ARMED) && wrapEdge;

    stateNext          = state;
    strobes            = '0;
    strobes.strayVec   = vecValid && !inRecvWindow;

    if (accept) begin
      case (gateOp_e'(instOp))
        OP_ALIGN, OP_SEND_START: stateNext = ST_DESKEW_WAIT;
        OP_RECV_START:           stateNext = ST_POLL;
        OP_TIME_CORRECT: begin
          if (argIsZero) begin
            stateNext         = ST_RUN;
            strobes.localLoad = 1'b1;
          end else begin
            stateNext         = ST_RUN_STALL;
            strobes.loadStall = 1'b1;
          end
        end
        default:                 stateNext = ST_RUN;
      endcase
    end else begin
      case (state)
        ST_DESKEW_WAIT, ST_ARMED: begin
          if (wrapEdge) stateNext = ST_RUN;
        end
        ST_POLL: begin
          if (vecValid) begin
            stateNext          = ST_ARMED;
            strobes.captureVec = 1'b1;
          end
        end
        ST_RUN_STALL: begin
          if (stallLast) begin
            stateNext         = ST_RUN;
            strobes.localLoad = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sendPend <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) sendPend <= (gateOp_e'(instOp) == OP_SEND_START);
    end
  end

endmodule

// File: rtl/epoch_issue_gate.sv
module epoch_issue_gate
  import epoch_gate_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int STALL_W = 8,
  parameter int VEC_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  logic [OP_W-1:0]    instOp,
  input  logic [STALL_W-1:0] instArg,
  input  logic [CNT_W-1:0]   globalCnt,
  input  logic               vecValid,
  input  logic [VEC_W-1:0]   vecData,
  output logic               issueEn,
  output logic               sendStrobe,
  output logic               recvFire,
  output logic [VEC_W-1:0]   recvData,
  output logic [CNT_W-1:0]   drift,
  output logic               protoErr
);

  gateStrobes_t strobes;
  logic         wrapEdge;
  logic         stallLast;
  logic         argIsZero;

  epoch_gate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instValid  (instValid),
    .instOp     (instOp),
    .argIsZero  (argIsZero),
    .wrapEdge   (wrapEdge),
    .stallLast  (stallLast),
    .vecValid   (vecValid),
    .issueEn    (issueEn),
    .sendStrobe (sendStrobe),
    .recvFire   (recvFire),
    .strobes    (strobes)
  );

  epoch_gate_dp #(
    .CNT_W   (CNT_W),
    .STALL_W (STALL_W),
    .VEC_W   (VEC_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .globalCnt (globalCnt),
    .instArg   (instArg),
    .vecData   (vecData),
    .strobes   (strobes),
    .wrapEdge  (wrapEdge),
    .stallLast (stallLast),
    .argIsZero (argIsZero),
    .drift     (drift),
    .recvData  (recvData),
    .protoErr  (protoErr)
  );

endmodule

// File: rtl/epoch_issue_gate_chk.sv
module epoch_issue_gate_chk
  import epoch_gate_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int STALL_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               instValid,
  input logic [OP_W-1:0]    instOp,
  input logic [STALL_W-1:0] instArg,
  input logic [CNT_W-1:0]   globalCnt,
  input logic               issueEn,
  input logic               sendStrobe,
  input logic               recvFire
);

  logic [CNT_W-1:0] seenGlobal;
  logic             alignHold;
  logic             recvHold;
  logic             taken;
  logic             boundary;

  assign taken    = instValid && issueEn;
  assign boundary = (seenGlobal == {CNT_W{1'b1}}) && (globalCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenGlobal <= '0;
      alignHold  <= 1'b0;
      recvHold   <= 1'b0;
    end else begin
      seenGlobal <= globalCnt;
      if (taken && (instOp == 3'd1 || instOp == 3'd2)) alignHold <= 1'b1;
      else if (boundary)                              alignHold <= 1'b0;
      if (taken && instOp == 3'd3) recvHold <= 1'b1;
      else if (recvFire)           recvHold <= 1'b0;
    end
  end

  // R2: while an align is pending, issue reopens only on a boundary
  assert_align_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    (alignHold && issueEn) |-> boundary);

  // R4: start strobe only on a boundary, and always with issue open
  assert_send_on_boundary_R4: assert property (@(posedge clk) disable iff (!rstN)
    sendStrobe |-> (boundary && issueEn));

  // R5: receiver start keeps issue closed until the receive is released
  assert_recv_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (recvHold && issueEn) |-> recvFire);

  // R6: receive release only on a boundary
  assert_recv_on_boundary_R6: assert property (@(posedge clk) disable iff (!rstN)
    recvFire |-> (boundary && issueEn));

  // R7: a nonzero correction stall closes issue on the next cycle
  assert_stall_closes_R7: assert property (@(posedge clk) disable iff (!rstN)
    (taken && instOp == 3'd4 && instArg != '0) |=> !issueEn);

  // R7: a zero-length correction stall does not close issue
  assert_zero_stall_open_R7: assert property (@(posedge clk) disable iff (!rstN)
    (taken && instOp == 3'd4 && instArg == '0) |=> issueEn);

endmodule

bind epoch_issue_gate epoch_issue_gate_chk #(
  .CNT_W   (CNT_W),
  .STALL_W (STALL_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .instValid  (instValid),
  .instOp     (instOp),
  .instArg    (instArg),
  .globalCnt  (globalCnt),
  .issueEn    (issueEn),
  .sendStrobe (sendStrobe),
  .recvFire   (recvFire)
);

// File: tb/test_epoch_issue_gate.sv
`timescale 1ns/1ps
module test_epoch_issue_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [2:0]  instOp = '0;
  logic [7:0]  instArg = '0;
  logic [7:0]  globalCnt = '0;
  logic        vecValid = 1'b0;
  logic [31:0] vecData = '0;
  logic        issueEn, sendStrobe, recvFire, protoErr;
  logic [31:0] recvData;
  logic [7:0]  drift;

  always #10 clk = ~clk;

  epoch_issue_gate i_epoch_issue_gate (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .instArg(instArg), .globalCnt(globalCnt), .vecValid(vecValid),
    .vecData(vecData), .issueEn(issueEn), .sendStrobe(sendStrobe),
    .recvFire(recvFire), .recvData(recvData), .drift(drift), .protoErr(protoErr)
  );

  int checks = 0;
  int fails  = 0;

  // stimulus for the next cycle
  int          gCur = 0;
  bit          ivQ = 0, vvQ = 0;
  int          opQ = 0, argQ = 0;
  logic [31:0] vdQ = '0;
  string       curTag = "R3";

  // reference model: 0 idle, 1 align wait, 2 waiting vector, 3 holding vector, 4 stalled, 5 running
  int          mMode = 0, mPrev = 0, mLocal = 0, mStall = 0, mErr = 0;
  bit          mPend = 0;
  logic [31:0] mBuf = '0;

  // last observed outputs
  bit          obsIssue, obsSend, obsRecv, obsErr;
  int          obsDrift, obsG;
  logic [31:0] obsData;

  task automatic cmp(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic evalCycle();
    bit wrap, eIssue, eSend, eRecv, acc;
    int nMode, nLocal;
    instValid = ivQ; instOp = 3'(opQ); instArg = 8'(argQ);
    vecValid = vvQ; vecData = vdQ; globalCnt = 8'(gCur);
    #1;
    wrap   = (mPrev == 255) && (gCur == 0);
    eIssue = (mMode == 0 || mMode == 5) || (wrap && (mMode == 1 || mMode == 3));
    eSend  = (mMode == 1) && wrap && mPend;
    eRecv  = (mMode == 3) && wrap;
    cmp(curTag, "issueEn", issueEn, eIssue);
    cmp("R4", "sendStrobe", sendStrobe, eSend);
    cmp("R6", "recvFire", recvFire, eRecv);
    cmp("R5", "recvData", recvData, mBuf);
    cmp("R8", "drift", drift, (gCur - mLocal) & 255);
    cmp("R9", "protoErr", protoErr, mErr);
    obsIssue = issueEn; obsSend = sendStrobe; obsRecv = recvFire; obsErr = protoErr;
    obsDrift = drift; obsG = gCur; obsData = recvData;
    // advance the model
    acc    = ivQ && eIssue;
    nMode  = mMode;
    nLocal = (mLocal + 1) & 255;
    mErr   = (vvQ && !(mMode == 2 || mMode == 3)) ? 1 : 0;
    if (acc) begin
      mPend = (opQ == 2);
      if (opQ == 1 || opQ == 2) nMode = 1;
      else if (opQ == 3) nMode = 2;
      else if (opQ == 4) begin
        if (argQ == 0) begin nMode = 5; nLocal = (gCur + 1) & 255; end
        else nMode = 4;
      end else nMode = 5;
    end else if ((mMode == 1 || mMode == 3) && wrap) nMode = 5;
    else if (mMode == 2 && vvQ) begin nMode = 3; mBuf = vdQ; end
    else if (mMode == 4 && mStall == 1) begin nMode = 5; nLocal = (gCur + 1) & 255; end
    if (acc && opQ == 4 && argQ != 0) mStall = argQ;
    else if (mStall != 0) mStall--;
    mMode = nMode; mLocal = nLocal; mPrev = gCur;
    ivQ = 0; vvQ = 0;
    gCur = (gCur + 1) % 256;
  endtask

  task automatic tick();
    @(negedge clk);
    evalCycle();
  endtask

  task automatic runTo(int g);
    while (gCur != g) tick();
  endtask

  task automatic issueOp(int op, int arg);
    ivQ = 1; opQ = op; argQ = arg;
    tick();
  endtask

  task automatic vecIn(logic [31:0] d);
    vvQ = 1; vdQ = d;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset values, checked while still in reset
    cmp("R1", "issueEn in reset", issueEn, 1);
    cmp("R1", "protoErr in reset", protoErr, 0);
    cmp("R1", "recvData in reset", recvData, 0);
    rstN = 1'b1;
    curTag = "R1";
    evalCycle();
    cmp("R1", "drift after reset", obsDrift, 0);

    // R3: plain operations keep issue open
    curTag = "R3";
    issueOp(0, 0); tick(); cmp("R3", "issue after op0", obsIssue, 1);
    issueOp(5, 0); tick(); cmp("R3", "issue after op5", obsIssue, 1);
    issueOp(7, 9); tick(); cmp("R3", "issue after op7", obsIssue, 1);

    // R2: align mid-epoch
    curTag = "R2";
    runTo(100);
    issueOp(1, 0);
    n = 0;
    for (int k = 0; k < 600; k++) begin tick(); if (obsIssue) break; n++; end
    cmp("R2", "closed cycles for align at 100", n, 155);
    cmp("R2", "reopen global value", obsG, 0);

    // R2: align accepted on a boundary waits one full epoch
    runTo(0);
    issueOp(1, 0);
    n = 0;
    for (int k = 0; k < 600; k++) begin tick(); if (obsIssue) break; n++; end
    cmp("R2", "closed cycles for align on boundary", n, 255);

    // R4: sender start
    curTag = "R4";
    runTo(30);
    issueOp(2, 0);
    n = 0;
    for (int k = 0; k < 600; k++) begin tick(); n++; if (obsSend) break; end
    cmp("R4", "cycles to start strobe", n, 226);
    cmp("R4", "strobe global value", obsG, 0);
    cmp("R4", "issue with strobe", obsIssue, 1);
    tick(); cmp("R4", "strobe single cycle", obsSend, 0);

    // R5, R6, R10: receiver start with a second vector
    curTag = "R5";
    runTo(10);
    issueOp(3, 0);
    runTo(50);
    vecIn(32'hA5A5_1234);
    tick(); cmp("R5", "stored vector", obsData, 32'hA5A5_1234);
    runTo(60);
    vecIn(32'h0BAD_0BAD);
    tick(); cmp("R10", "no error on second vector", obsErr, 0);
    cmp("R10", "first vector kept", obsData, 32'hA5A5_1234);
    for (int k = 0; k < 600; k++) begin tick(); if (obsRecv) break; end
    cmp("R6", "receive global value", obsG, 0);
    cmp("R6", "issue with receive", obsIssue, 1);
    cmp("R10", "data at receive", obsData, 32'hA5A5_1234);

    // R6: vector stored on a boundary cycle
    curTag = "R6";
    runTo(200);
    issueOp(3, 0);
    runTo(0);
    vecIn(32'hC0DE_7777);
    n = 0;
    for (int k = 0; k < 600; k++) begin tick(); n++; if (obsRecv) break; end
    cmp("R6", "cycles from boundary vector to receive", n, 256);
    cmp("R5", "boundary vector stored", obsData, 32'hC0DE_7777);

    // R8, R7: drift and correction stall
    curTag = "R7";
    runTo(20);
    gCur = 23;
    tick(); cmp("R8", "drift after jump", obsDrift, 3);
    issueOp(4, 5);
    n = 0;
    for (int k = 0; k < 50; k++) begin tick(); if (obsIssue) break; n++; end
    cmp("R7", "stall length 5", n, 5);
    cmp("R8", "drift after stall", obsDrift, 0);
    gCur = gCur + 7;
    tick(); cmp("R8", "drift after second jump", obsDrift, 7);
    issueOp(4, 0);
    cmp("R7", "zero stall accept drift", obsDrift, 7);
    tick(); cmp("R7", "zero stall no closure", obsIssue, 1);
    cmp("R8", "drift after zero stall", obsDrift, 0);

    // R9: stray vectors
    curTag = "R9";
    vecIn(32'h1111_2222);
    tick(); cmp("R9", "error after stray vector", obsErr, 1);
    tick(); cmp("R9", "error single cycle", obsErr, 0);
    issueOp(4, 3);
    vecIn(32'h3333_4444);
    tick(); cmp("R9", "error for vector during stall", obsErr, 1);
    repeat (6) tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule